// File: doc/BRIEF.md
# FIFO-Buffered SPI Master

This block is a register-mapped SPI master. Software programs a clock divider, a control word and an interrupt enable. It then writes words into an eight-deep transmit queue and reads the words that came back from an eight-deep receive queue. The shift engine sends words of 2 to 16 bits, MSB or LSB first, in any combination of clock polarity and phase. An internal loopback path feeds the serial output back to the serial input.

A soft-reset bit flushes both queues and parks the shifter without touching the other settings. A level interrupt tells software that every queued word has left the shifter, which is the point at which the received words can be collected.

Top module: `spim_top`

## Requirements
- R1: After reset every register reads 0, SCK and MOSI are low, IRQ is low, and a read of the receive buffer returns 0.
- R2: The divider register (offset 0x00, 16 bits) sets the SCK half-period in system clocks. A value of 0 means 65536.
- R3: Control bits [3:0] (offset 0x0C) hold the word length minus one. A received word is right-justified and its unused upper bits read 0.
- R4: Control bit 4 set shifts MSB first. Clear, it shifts LSB first. This applies to both MOSI and MISO.
- R5: Control bit 6 sets the SCK idle level. With control bit 5 clear, data is sampled on the leading SCK edge and changed on the trailing edge. With bit 5 set, data is changed on the leading edge and sampled on the trailing edge.
- R6: Words leave the transmit queue only while control bit 9 (enable) and bit 8 (master) are both set. Otherwise they wait, and SCK stays idle.
- R7: IRQ equals interrupt-enable bit 2 (offset 0x10) AND transmit queue empty AND shifter idle. It is a level.
- R8: Each write to offset 0x04 queues one word. The transmit queue holds 8 words with control bit 11 set and 1 word with it clear. A write to a full queue is dropped.
- R9: Each read of offset 0x08 returns and removes the oldest received word, and an empty queue reads 0. The receive queue holds 8 words with control bit 12 set and 1 word with it clear. A word arriving at a full queue replaces the oldest one and sets a sticky overrun flag, which reads back at control bit 14.
- R10: While control bit 7 (soft reset) is set, both queues are empty, the shifter is idle with SCK at the polarity level, and the overrun flag is cleared. All other register bits keep their values.
- R11: Control bit 10 set makes the receiver sample MOSI instead of the MISO pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 1 | Register access strobe, one cycle per access |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 5 | Byte address of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the same cycle as regSel |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Transmit-done interrupt level |

## Verification
A wrong edge index or bit counter in the shifter shows up as a corrupted word on MOSI, or in the receive queue, at the end of that same word. SCK also lands on the wrong idle level after the final edge. A queue pointer or count error shows within one queue depth of words, as a missing, duplicated or reordered word when the queue is drained, or as an overrun flag that disagrees with the number of words sent. A divider fault is visible within the first two SCK edges of a transfer as a wrong half-period. A fault in the interrupt condition shows in the cycle the last word finishes.

// File: rtl/spim_pkg.sv
package spim_pkg;

  // Decoded control-register fields
  typedef struct packed {
    logic [3:0] wlenM1;
    logic       msbFirst;
    logic       cpha;
    logic       cpol;
    logic       softRst;
    logic       master;
    logic       enable;
    logic       loop;
    logic       txFifoEn;
    logic       rxFifoEn;
  } spimCfg_t;

  // One-cycle strobes from the register side to the datapath
  typedef struct packed {
    logic txPush;
    logic rxPop;
  } spimStrobe_t;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W = 16,
  parameter int DEPTH = 8,
  parameter bit OVERWRITE = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         flush,
  input  logic         single,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPop, doPush, dropOld;

  assign empty = (count == '0);
  assign full  = single ? (count != '0) : (count == CNT_W'(DEPTH));
  assign doPop = pop && !empty;
  assign rdata = mem[rdPtr];

  generate
    if (OVERWRITE) begin : g_overwrite
      assign dropOld = push && full && !doPop;
      assign doPush  = push;
    end else begin : g_drop
      assign dropOld = 1'b0;
      assign doPush  = push && (!full || doPop);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + PTR_W'(1);
      if (doPop || dropOld) rdPtr <= rdPtr + PTR_W'(1);
      count <= count + CNT_W'(doPush) - CNT_W'(doPop || dropOld);
    end
  end

  // R8/R9: a push into a full queue never changes its occupancy
  p_full_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    push && full && !pop && !flush |=> $stable(count));

endmodule

// File: rtl/spim_dp.sv
module spim_dp
  import spim_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH = 8,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  spimCfg_t          cfg,
  input  logic [DIV_W-1:0]  divVal,
  input  spimStrobe_t       stb,
  input  logic [DATA_W-1:0] txData,
  input  logic              miso,
  output logic [DATA_W-1:0] rxHead,
  output logic              rxEmpty,
  output logic              txEmpty,
  output logic              busy,
  output logic              overrun,
  output logic              sck,
  output logic              mosi
);
  localparam int LEN_W = $clog2(DATA_W + 1);
  localparam int IDX_W = $clog2(DATA_W);

  logic              flush, run, startW, tick, lastEdge, sampleNow, shiftNow;
  logic              txFull, rxFull, rxPush, misoIn, sckTgl, mosiR;
  logic [DATA_W-1:0] txHead, txWord, rxWord, rxNext, rxPushData;
  logic [LEN_W-1:0]  len, outCnt, rxCnt;
  logic [LEN_W:0]    edgeIdx, lastVal;
  logic [DIV_W:0]    halfCnt, divReal;
  logic [IDX_W-1:0]  idxFirst, idxOut, idxIn;

  function automatic logic [IDX_W-1:0] bitPos(input logic [LEN_W-1:0] k,
                                              input logic msb,
                                              input logic [LEN_W-1:0] l);
    logic [LEN_W-1:0] t;
    t = msb ? (l - k - LEN_W'(1)) : k;
    return t[IDX_W-1:0];
  endfunction

  assign flush    = cfg.softRst;
  assign run      = cfg.enable && cfg.master && !flush;
  assign len      = LEN_W'(cfg.wlenM1) + LEN_W'(1);
  assign lastVal  = {len, 1'b0} - (LEN_W+1)'(1);
  assign divReal  = (divVal == '0) ? {1'b1, {DIV_W{1'b0}}} : {1'b0, divVal};
  assign startW   = run && !busy && !txEmpty;
  assign tick     = busy && (halfCnt == (DIV_W+1)'(1));
  assign lastEdge = (edgeIdx == lastVal);
  assign sampleNow = tick && (edgeIdx[0] == cfg.cpha);
  assign shiftNow  = tick && (edgeIdx[0] != cfg.cpha) && !lastEdge;
  assign misoIn   = cfg.loop ? mosiR : miso;
  assign idxFirst = bitPos('0, cfg.msbFirst, len);
  assign idxOut   = bitPos(outCnt, cfg.msbFirst, len);
  assign idxIn    = bitPos(rxCnt, cfg.msbFirst, len);

  always_comb begin
    rxNext = rxWord;
    rxNext[idxIn] = misoIn;
  end

  assign rxPush     = tick && lastEdge;
  assign rxPushData = sampleNow ? rxNext : rxWord;

  spim_fifo #(.W(DATA_W), .DEPTH(DEPTH), .OVERWRITE(1'b0)) u_txq (
    .clk(clk), .rstN(rstN), .flush(flush), .single(!cfg.txFifoEn),
    .push(stb.txPush), .pop(startW), .wdata(txData), .rdata(txHead),
    .empty(txEmpty), .full(txFull)
  );

  spim_fifo #(.W(DATA_W), .DEPTH(DEPTH), .OVERWRITE(1'b1)) u_rxq (
    .clk(clk), .rstN(rstN), .flush(flush), .single(!cfg.rxFifoEn),
    .push(rxPush), .pop(stb.rxPop), .wdata(rxPushData), .rdata(rxHead),
    .empty(rxEmpty), .full(rxFull)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; sckTgl <= 1'b0; mosiR <= 1'b0;
      halfCnt <= '0; edgeIdx <= '0; outCnt <= '0; rxCnt <= '0;
      txWord <= '0; rxWord <= '0; overrun <= 1'b0;
    end else if (flush) begin
      busy <= 1'b0; sckTgl <= 1'b0; mosiR <= 1'b0;
      halfCnt <= '0; edgeIdx <= '0; outCnt <= '0; rxCnt <= '0;
      rxWord <= '0; overrun <= 1'b0;
    end else begin
      if (rxPush && rxFull && !stb.rxPop) overrun <= 1'b1;
      if (startW) begin
        busy    <= 1'b1;
        txWord  <= txHead;
        halfCnt <= divReal;
        edgeIdx <= '0;
        rxWord  <= '0;
        rxCnt   <= '0;
        if (!cfg.cpha) begin
          mosiR  <= txHead[idxFirst];
          outCnt <= LEN_W'(1);
        end else begin
          outCnt <= '0;
        end
      end else if (tick) begin
        sckTgl  <= !sckTgl;
        halfCnt <= divReal;
        edgeIdx <= edgeIdx + (LEN_W+1)'(1);
        if (sampleNow) begin
          rxWord <= rxNext;
          rxCnt  <= rxCnt + LEN_W'(1);
        end
        if (shiftNow) begin
          mosiR  <= txWord[idxOut];
          outCnt <= outCnt + LEN_W'(1);
        end
        if (lastEdge) busy <= 1'b0;
      end else if (busy) begin
        halfCnt <= halfCnt - (DIV_W+1)'(1);
      end
    end
  end

  assign sck  = cfg.cpol ^ sckTgl;
  assign mosi = mosiR;

  // R5: an idle shifter always leaves SCK at the polarity level
  p_idle_sck_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sck == cfg.cpol);

  // R6: no word starts unless enable and master are both set
  p_start_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    !run && !busy |=> !busy);

  // R9: a word landing on a full receive queue raises the sticky flag
  p_overrun_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxPush && rxFull && !stb.rxPop && !flush |=> overrun);

  // R10: soft reset empties both queues and parks the shifter
  p_flush_r10: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !busy && txEmpty && rxEmpty && !overrun);

  logic unusedTxFull;
  assign unusedTxFull = txFull;

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W = 16,
  parameter int BUS_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]  regWdata,
  output logic [BUS_W-1:0]  regRdata,
  input  logic [DATA_W-1:0] rxHead,
  input  logic              rxEmpty,
  input  logic              txEmpty,
  input  logic              busy,
  input  logic              overrun,
  output spimCfg_t          cfg,
  output logic [DIV_W-1:0]  divVal,
  output spimStrobe_t       stb,
  output logic [DATA_W-1:0] txData,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] IDX_DIV = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_TX  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_RX  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_CTL = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_IEN = IDX_W'(4);

  logic [IDX_W-1:0] regIdx;
  logic             wrEn, rdEn, ienReg;
  logic [12:0]      ctrlReg;
  logic             unusedBits;

  assign regIdx = regAddr[ADDR_W-1:2];
  assign wrEn   = regSel && regWrite;
  assign rdEn   = regSel && !regWrite;
  assign unusedBits = ^{regWdata[BUS_W-1:DIV_W], regAddr[1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divVal  <= '0;
      ctrlReg <= '0;
      ienReg  <= 1'b0;
    end else if (wrEn) begin
      case (regIdx)
        IDX_DIV: divVal  <= regWdata[DIV_W-1:0];
        IDX_CTL: ctrlReg <= regWdata[12:0];
        IDX_IEN: ienReg  <= regWdata[2];
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg.wlenM1   = ctrlReg[3:0];
    cfg.msbFirst = ctrlReg[4];
    cfg.cpha     = ctrlReg[5];
    cfg.cpol     = ctrlReg[6];
    cfg.softRst  = ctrlReg[7];
    cfg.master   = ctrlReg[8];
    cfg.enable   = ctrlReg[9];
    cfg.loop     = ctrlReg[10];
    cfg.txFifoEn = ctrlReg[11];
    cfg.rxFifoEn = ctrlReg[12];
  end

  assign stb.txPush = wrEn && (regIdx == IDX_TX);
  assign stb.rxPop  = rdEn && (regIdx == IDX_RX) && !rxEmpty;
  assign txData     = regWdata[DATA_W-1:0];

  always_comb begin
    regRdata = '0;
    case (regIdx)
      IDX_DIV: regRdata = BUS_W'(divVal);
      IDX_RX:  regRdata = rxEmpty ? '0 : BUS_W'(rxHead);
      IDX_CTL: regRdata = BUS_W'({overrun, 1'b0, ctrlReg});
      IDX_IEN: regRdata = BUS_W'({ienReg, 2'b00});
      default: regRdata = '0;
    endcase
  end

  assign irq = ienReg && txEmpty && !busy;

endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH = 8,
  parameter int DIV_W = 16,
  parameter int BUS_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]  regWdata,
  output logic [BUS_W-1:0]  regRdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  spimCfg_t          cfg;
  spimStrobe_t       stb;
  logic [DIV_W-1:0]  divVal;
  logic [DATA_W-1:0] txData, rxHead;
  logic              rxEmpty, txEmpty, busy, overrun;

  spim_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .rxHead(rxHead), .rxEmpty(rxEmpty), .txEmpty(txEmpty), .busy(busy),
    .overrun(overrun), .cfg(cfg), .divVal(divVal), .stb(stb),
    .txData(txData), .irq(irq)
  );

  spim_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH), .DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .divVal(divVal), .stb(stb),
    .txData(txData), .miso(miso), .rxHead(rxHead), .rxEmpty(rxEmpty),
    .txEmpty(txEmpty), .busy(busy), .overrun(overrun), .sck(sck), .mosi(mosi)
  );

endmodule

// File: tb/tb_spim_top.sv
module tb_spim_top;
  localparam logic [4:0] A_DIV = 5'h00, A_TX = 5'h04, A_RX = 5'h08,
                         A_CTL = 5'h0C, A_IEN = 5'h10;
  localparam logic [31:0] C_MS = 32'h100, C_EN = 32'h200, C_LPB = 32'h400,
                          C_TXF = 32'h800, C_RXF = 32'h1000, C_SR = 32'h80,
                          C_OVR = 32'h4000;
  localparam logic [31:0] C_BASE = C_MS | C_EN | C_TXF | C_RXF;
  localparam logic [31:0] C_LOOP16 = C_BASE | C_LPB | 32'hF;

  // {wlenM1, msbFirst, cpha, cpol, txWord, slaveReply}
  localparam int NVEC = 8;
  localparam logic [38:0] VEC [NVEC] = '{
    {4'h7, 1'b1, 1'b0, 1'b0, 16'h00A5, 16'h003C},
    {4'h7, 1'b1, 1'b1, 1'b0, 16'h00C3, 16'h0081},
    {4'h7, 1'b1, 1'b0, 1'b1, 16'h005A, 16'h00E7},
    {4'h7, 1'b1, 1'b1, 1'b1, 16'h0096, 16'h0018},
    {4'hF, 1'b0, 1'b0, 1'b0, 16'hBEEF, 16'h1234},
    {4'hF, 1'b0, 1'b1, 1'b1, 16'h8001, 16'hF00D},
    {4'h1, 1'b1, 1'b0, 1'b0, 16'h0002, 16'h0001},
    {4'h4, 1'b0, 1'b1, 1'b0, 16'h0013, 16'h000A}
  };

  logic        clk = 1'b0, rstN = 1'b0;
  logic        regSel = 1'b0, regWrite = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic        sck, mosi, irq;
  logic        miso = 1'b0;

  int checks = 0, failures = 0;
  bit doneFlag = 0;

  // slave model state
  int          slvLen = 8, slvIn = 0, slvOut = 0;
  logic        slvMsb = 1'b1, slvCpha = 1'b0, slvCpol = 1'b0, slvPrev = 1'b0;
  logic [15:0] slvReply = '0, slvCap = '0;

  spim_top dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .sck(sck), .mosi(mosi), .miso(miso), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic int spos(input int k);
    return slvMsb ? (slvLen - 1 - k) : k;
  endfunction

  // SPI slave: reacts at negedges to SCK edges made at the preceding posedge
  initial begin
    forever begin
      @(negedge clk);
      if (sck !== slvPrev) begin
        if ((sck != slvCpol) ^ slvCpha) begin
          if (slvIn < slvLen) slvCap[spos(slvIn)] = mosi;
          slvIn++;
        end else begin
          if (slvOut < slvLen) miso = slvReply[spos(slvOut)];
          slvOut++;
        end
        slvPrev = sck;
      end
    end
  end

  task automatic armSlave(input int l, input logic msb, input logic cpha,
                          input logic cpol, input logic [15:0] reply);
    slvLen = l; slvMsb = msb; slvCpha = cpha; slvCpol = cpol;
    slvReply = reply; slvCap = '0; slvIn = 0;
    if (!cpha) begin
      miso = reply[spos(0)];
      slvOut = 1;
    end else begin
      slvOut = 0;
    end
    slvPrev = sck;
  endtask

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regSel = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regSel = 1'b0; regWrite = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regSel = 1'b1; regWrite = 1'b0; regAddr = a;
    #1 d = regRdata;
    @(posedge clk); #1;
    regSel = 1'b0;
  endtask

  task automatic waitIrq();
    int n = 0;
    @(negedge clk);
    while (!irq && n < 40000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic measureHalf(output int n);
    logic p;
    int guard = 0;
    @(negedge clk);
    p = sck;
    while (sck == p && guard < 2000) begin @(negedge clk); guard++; end
    p = sck; n = 0;
    while (sck == p && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic summary();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [16:0] mask;
    int n;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    rd(A_CTL, d); check(d == 0, "R1 ctrl after reset", d, 0);
    rd(A_DIV, d); check(d == 0, "R1 divider after reset", d, 0);
    rd(A_RX, d);  check(d == 0, "R1 empty rx read", d, 0);
    check(sck == 1'b0 && mosi == 1'b0, "R1 sck/mosi low", {sck, mosi}, 0);
    check(irq == 1'b0, "R1 irq low", irq, 0);

    wr(A_DIV, 32'd7);
    wr(A_IEN, 32'h4);
    @(negedge clk);
    check(irq == 1'b1, "R7 irq high when idle and enabled", irq, 1);

    // R3 R4 R5: one word per vector against the slave model
    for (int v = 0; v < NVEC; v++) begin
      logic [3:0] wl; logic msb, ph, po; logic [15:0] tx, rep;
      {wl, msb, ph, po, tx, rep} = VEC[v];
      mask = (17'd1 << (wl + 1)) - 17'd1;
      wr(A_CTL, C_BASE | 32'(wl) | (32'(msb) << 4) | (32'(ph) << 5) | (32'(po) << 6));
      armSlave(int'(wl) + 1, msb, ph, po, rep);
      wr(A_TX, 32'(tx));
      waitIrq();
      rd(A_RX, d);
      check(d == 32'(rep & mask[15:0]), "R3 R4 R5 received word", d, 32'(rep & mask[15:0]));
      check(slvCap == (tx & mask[15:0]), "R4 R5 word seen on mosi", 32'(slvCap), 32'(tx & mask[15:0]));
      check(sck == po, "R5 sck idle level", sck, po);
    end

    // R2 R11: half-period measurement in loopback with miso held low
    wr(A_CTL, C_LOOP16);
    armSlave(16, 1'b1, 1'b0, 1'b0, 16'h0000);
    wr(A_TX, 32'hC35A);
    measureHalf(n);
    check(n == 7, "R2 half period for divider 7", n, 7);
    check(irq == 1'b0, "R7 irq low while shifting", irq, 0);
    waitIrq();
    rd(A_RX, d); check(d == 32'hC35A, "R11 loopback word", d, 32'hC35A);
    wr(A_DIV, 32'd10);
    armSlave(16, 1'b1, 1'b0, 1'b0, 16'h0000);
    wr(A_TX, 32'h0F0F);
    measureHalf(n);
    check(n == 10, "R2 half period for divider 10", n, 10);
    waitIrq();
    rd(A_RX, d); check(d == 32'h0F0F, "R11 loopback word 2", d, 32'h0F0F);

    // R2 R10: divider 0 means 65536, then soft reset aborts the word
    wr(A_DIV, 32'd0);
    wr(A_TX, 32'h1234);
    repeat (3000) @(negedge clk);
    check(sck == 1'b0 && irq == 1'b0, "R2 divider 0 no edge yet", {sck, irq}, 0);
    wr(A_CTL, C_LOOP16 | C_SR);
    repeat (2) @(negedge clk);
    check(irq == 1'b1 && sck == 1'b0, "R10 soft reset parks shifter", {irq, sck}, 2'b10);
    rd(A_CTL, d); check(d == (C_LOOP16 | C_SR), "R10 other bits kept", d, C_LOOP16 | C_SR);
    rd(A_RX, d);  check(d == 0, "R10 rx flushed", d, 0);
    wr(A_CTL, C_LOOP16);
    wr(A_DIV, 32'd7);

    // R6 R8: queue with shifting disabled, nine writes
    wr(A_CTL, C_LOOP16 & ~C_EN);
    for (int i = 0; i < 9; i++) wr(A_TX, 32'h2200 + 32'(i));
    repeat (300) @(negedge clk);
    check(irq == 1'b0 && sck == 1'b0, "R6 no shifting while disabled", {irq, sck}, 0);
    rd(A_RX, d); check(d == 0, "R6 nothing received while disabled", d, 0);
    wr(A_CTL, C_LOOP16);
    waitIrq();
    for (int i = 0; i < 8; i++) begin
      rd(A_RX, d);
      check(d == 32'h2200 + 32'(i), "R8 R9 queued word order", d, 32'h2200 + 32'(i));
    end
    rd(A_RX, d); check(d == 0, "R8 ninth write dropped", d, 0);
    rd(A_CTL, d); check((d & C_OVR) == 0, "R9 no overrun at exact fill", d & C_OVR, 0);

    // R9: nine words into the receive queue
    for (int i = 0; i < 8; i++) wr(A_TX, 32'h3300 + 32'(i));
    waitIrq();
    wr(A_TX, 32'h3308);
    waitIrq();
    rd(A_CTL, d); check((d & C_OVR) == C_OVR, "R9 overrun flag set", d & C_OVR, C_OVR);
    for (int i = 1; i < 9; i++) begin
      rd(A_RX, d);
      check(d == 32'h3300 + 32'(i), "R9 oldest word replaced", d, 32'h3300 + 32'(i));
    end
    wr(A_CTL, C_LOOP16 | C_SR);
    repeat (2) @(negedge clk);
    rd(A_CTL, d); check((d & C_OVR) == 0, "R10 soft reset clears overrun", d & C_OVR, 0);

    // R8 R9: queues disabled act as single-word buffers
    wr(A_CTL, C_MS | C_LPB | 32'hF);
    wr(A_TX, 32'h4400);
    wr(A_TX, 32'h4401);
    wr(A_CTL, C_MS | C_EN | C_LPB | 32'hF);
    waitIrq();
    rd(A_RX, d); check(d == 32'h4400, "R8 single tx buffer first word", d, 32'h4400);
    rd(A_RX, d); check(d == 0, "R8 single tx buffer dropped second", d, 0);
    wr(A_TX, 32'h4402); waitIrq();
    wr(A_TX, 32'h4403); waitIrq();
    rd(A_CTL, d); check((d & C_OVR) == C_OVR, "R9 single rx overrun", d & C_OVR, C_OVR);
    rd(A_RX, d); check(d == 32'h4403, "R9 single rx keeps newest", d, 32'h4403);

    // R7: interrupt disabled
    wr(A_IEN, 32'h0);
    @(negedge clk);
    check(irq == 1'b0, "R7 irq off when disabled", irq, 0);

    summary();
    $finish;
  end
endmodule